// File: doc/BRIEF.md
# Write Buffer with Range Merging and Drain Mode Control

This block sits in front of a memory controller's command scheduler and keeps pending write requests in a small circular buffer. Each request is tracked only by its start address and byte count. When a new write arrives, the block compares it with every buffered entry. If the new write overlaps an entry or sits directly next to it, the write is folded into that entry and no new slot is used. This saves bursts that would otherwise write the same row region twice. Data payloads and DRAM timing are kept elsewhere.

The block also decides whether the controller is serving reads or draining writes. Write mode starts when the buffer fills to a high threshold, or when no reads are waiting and writes are pending. Write mode ends once occupancy falls below a low threshold while reads are waiting, or once the buffer is empty. The high threshold may be set to a completely full buffer, and that setting still starts a drain. In write mode the oldest entry is presented for issue. Consecutive issues are kept a minimum number of cycles apart, so the buffer never empties in zero time.

Top module: `wbuf_merge_drain`

## Requirements
- R1: After reset, occupancy is 0, the mode is read (mode_write = 0), drain_valid is 0 and wr_ready is 1.
- R2: An accepted write that touches no eligible entry is stored in a new slot at the tail of the buffer, and occupancy rises by one.
- R3: An accepted write whose byte range overlaps an eligible entry replaces that entry with the union of the two ranges, and occupancy is unchanged.
- R4: A write that ends exactly where an entry starts, or starts exactly where an entry ends, merges the same way as an overlap.
- R5: A merge is allowed only if the union spans at most BURST bytes (64 by default). Otherwise the write takes a new slot. Every drained length lies in 1..BURST, provided the written lengths lie in 1..BURST.
- R6: When several entries qualify, the write merges into the oldest one. The oldest entry is not eligible in a cycle where it is being drained.
- R7: When the buffer holds DEPTH entries and no merge is possible, wr_ready is 0 and the write is ignored: occupancy and buffer contents are unchanged.
- R8: In read mode, occupancy at or above the high threshold switches to write mode at the next clock edge. With the default of 100 percent, the threshold is a full buffer of 8 entries.
- R9: In read mode, rdq_empty = 1 together with nonzero occupancy switches to write mode at the next clock edge.
- R10: In write mode, the block returns to read mode at the next edge when occupancy is 0, or when occupancy is below the low threshold (4 by default) and rdq_empty = 0.
- R11: drain_valid is 1 only in write mode with a nonzero occupancy. It presents the oldest entry's start address and byte count. drain_valid and drain_ready together remove that entry.
- R12: Two removals are at least GAP clock cycles apart (4 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Incoming write request present |
| wr_addr | input | ADDR_W | Start byte address of the incoming write |
| wr_len | input | LEN_W | Byte count of the incoming write, 1..BURST |
| wr_ready | output | 1 | Incoming write can be taken this cycle |
| rdq_empty | input | 1 | No reads are waiting in the controller |
| mode_write | output | 1 | 1 = draining writes, 0 = serving reads |
| occupancy | output | $clog2(DEPTH+1) | Number of buffered entries |
| drain_valid | output | 1 | An entry is offered for issue |
| drain_addr | output | ADDR_W | Start address of the offered entry |
| drain_len | output | LEN_W | Byte count of the offered entry |
| drain_ready | input | 1 | The scheduler takes the offered entry |

## Verification
A wrong merge decision shows up in two ways. Occupancy differs from the expected value one cycle after the write. The wrong range appears on drain_addr and drain_len only when that entry later reaches the head in write mode, which can be many cycles later, so the bench tracks every entry and compares each drained entry exactly. A wrong head pointer or age order shows on the first drain that follows. A faulty mode decision shows on mode_write one edge after the occupancy that should have caused it. A faulty spacing counter shows as two removals closer than GAP cycles, or as an offer held back longer than GAP cycles.

// File: rtl/wbuf_pkg.sv
`timescale 1ns/1ps
package wbuf_pkg;

  typedef enum logic {
    WB_MODE_RD = 1'b0,
    WB_MODE_WR = 1'b1
  } wb_mode_e;

  // Turn a percentage of the buffer depth into an entry count.
  // Rounding up keeps a nonzero percentage from collapsing to zero entries.
  function automatic int unsigned pct_to_count(int unsigned depth, int unsigned pct,
                                               bit round_up, int unsigned floor_val);
    int unsigned v;
    v = round_up ? (depth * pct + 99) / 100 : (depth * pct) / 100;
    if (v > depth)     v = depth;
    if (v < floor_val) v = floor_val;
    return v;
  endfunction

endpackage

// File: rtl/wbuf_merge_find.sv
`timescale 1ns/1ps
// Compares an incoming range against every live entry and reports the oldest one it can merge into.
module wbuf_merge_find #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 7,
  parameter int BURST  = 64,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
  input  logic [DEPTH-1:0][LEN_W-1:0]  ent_len,
  input  logic [PW-1:0]                head,
  input  logic [CW-1:0]                count,
  input  logic                         skip_head,
  input  logic [ADDR_W-1:0]            in_addr,
  input  logic [LEN_W-1:0]             in_len,
  output logic                         hit,
  output logic [PW-1:0]                hit_idx,
  output logic [ADDR_W-1:0]            hit_lo,
  output logic [LEN_W-1:0]             hit_len
);

  localparam int EW = ADDR_W + 1;

  function automatic logic [EW-1:0] range_end(logic [ADDR_W-1:0] a, logic [LEN_W-1:0] n);
    return EW'(a) + EW'(n);
  endfunction

  // Touching includes exact adjacency: end of one equals start of the other.
  function automatic logic range_touch(logic [ADDR_W-1:0] sa, logic [LEN_W-1:0] sn,
                                       logic [ADDR_W-1:0] ia, logic [LEN_W-1:0] il);
    return (EW'(ia) <= range_end(sa, sn)) && (EW'(sa) <= range_end(ia, il));
  endfunction

  function automatic logic [ADDR_W-1:0] union_lo(logic [ADDR_W-1:0] sa, logic [ADDR_W-1:0] ia);
    return (sa < ia) ? sa : ia;
  endfunction

  function automatic logic [EW-1:0] union_span(logic [ADDR_W-1:0] sa, logic [LEN_W-1:0] sn,
                                               logic [ADDR_W-1:0] ia, logic [LEN_W-1:0] il);
    logic [EW-1:0] e0, e1, hi;
    e0 = range_end(sa, sn);
    e1 = range_end(ia, il);
    hi = (e0 > e1) ? e0 : e1;
    return hi - EW'(union_lo(sa, ia));
  endfunction

  always_comb begin
    logic [PW-1:0] idx;
    logic [EW-1:0] span;
    hit     = 1'b0;
    hit_idx = '0;
    hit_lo  = '0;
    hit_len = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx  = head + PW'(k);
      span = union_span(ent_addr[idx], ent_len[idx], in_addr, in_len);
      if (!hit && (CW'(k) < count) && !((k == 0) && skip_head) &&
          range_touch(ent_addr[idx], ent_len[idx], in_addr, in_len) &&
          (span <= EW'(BURST))) begin
        hit     = 1'b1;
        hit_idx = idx;
        hit_lo  = union_lo(ent_addr[idx], in_addr);
        hit_len = LEN_W'(span);
      end
    end
  end

endmodule

// File: rtl/wbuf_mode_ctl.sv
`timescale 1ns/1ps
// Read/write mode decision with hysteresis between a high and a low occupancy mark.
module wbuf_mode_ctl
  import wbuf_pkg::*;
#(
  parameter int CW     = 4,
  parameter int HI_CNT = 8,
  parameter int LO_CNT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          rdq_empty,
  output logic          mode_write
);

  wb_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      WB_MODE_RD:
        if ((count >= CW'(HI_CNT)) || (rdq_empty && (count != '0))) mode_d = WB_MODE_WR;
      WB_MODE_WR:
        if ((count == '0) || ((count < CW'(LO_CNT)) && !rdq_empty)) mode_d = WB_MODE_RD;
      default: mode_d = WB_MODE_RD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= WB_MODE_RD;
    else        mode_q <= mode_d;
  end

  assign mode_write = (mode_q == WB_MODE_WR);

endmodule

// File: rtl/wbuf_issue_gap.sv
`timescale 1ns/1ps
// Enforces a minimum number of cycles between two drained entries.
module wbuf_issue_gap #(
  parameter int GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic gap_ok
);

  generate
    if (GAP <= 1) begin : g_free
      assign gap_ok = 1'b1;
    end else begin : g_count
      localparam int GW = $clog2(GAP);
      logic [GW-1:0] wait_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            wait_q <= '0;
        else if (fire)         wait_q <= GW'(GAP - 1);
        else if (wait_q != '0) wait_q <= wait_q - 1'b1;
      end
      assign gap_ok = (wait_q == '0);
    end
  endgenerate

endmodule

// File: rtl/wbuf_merge_drain.sv
`timescale 1ns/1ps
module wbuf_merge_drain
  import wbuf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 7,
  parameter int BURST  = 64,
  parameter int HI_PCT = 100,
  parameter int LO_PCT = 50,
  parameter int GAP    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_valid,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [LEN_W-1:0]             wr_len,
  output logic                         wr_ready,
  input  logic                         rdq_empty,
  output logic                         mode_write,
  output logic [$clog2(DEPTH+1)-1:0]   occupancy,
  output logic                         drain_valid,
  output logic [ADDR_W-1:0]            drain_addr,
  output logic [LEN_W-1:0]             drain_len,
  input  logic                         drain_ready
);

  localparam int PW     = $clog2(DEPTH);
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int HI_CNT = int'(pct_to_count(DEPTH, HI_PCT, 1'b1, 1));
  localparam int LO_CNT = int'(pct_to_count(DEPTH, LO_PCT, 1'b0, 0));

  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
  logic [DEPTH-1:0][LEN_W-1:0]  ent_len;
  logic [PW-1:0]                head_q;
  logic [CW-1:0]                count_q;
  logic [PW-1:0]                tail;

  // Named internal events for the checker
  logic              drain_fire;
  logic              merge_hit;
  logic              accept;
  logic              alloc;
  logic              do_merge;
  logic              buf_full;
  logic              gap_ok;
  logic [PW-1:0]     merge_idx;
  logic [ADDR_W-1:0] merge_lo;
  logic [LEN_W-1:0]  merge_len;

  assign tail        = head_q + count_q[PW-1:0];
  assign buf_full    = (count_q == CW'(DEPTH));
  assign drain_valid = mode_write && (count_q != '0) && gap_ok;
  assign drain_fire  = drain_valid && drain_ready;
  assign wr_ready    = !buf_full || merge_hit;
  assign accept      = wr_valid && wr_ready;
  assign do_merge    = accept && merge_hit;
  assign alloc       = accept && !merge_hit;

  wbuf_merge_find #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST(BURST)
  ) find_i (
    .ent_addr (ent_addr),
    .ent_len  (ent_len),
    .head     (head_q),
    .count    (count_q),
    .skip_head(drain_fire),
    .in_addr  (wr_addr),
    .in_len   (wr_len),
    .hit      (merge_hit),
    .hit_idx  (merge_idx),
    .hit_lo   (merge_lo),
    .hit_len  (merge_len)
  );

  wbuf_mode_ctl #(
    .CW(CW), .HI_CNT(HI_CNT), .LO_CNT(LO_CNT)
  ) mode_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (count_q),
    .rdq_empty (rdq_empty),
    .mode_write(mode_write)
  );

  wbuf_issue_gap #(.GAP(GAP)) gap_i (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (drain_fire),
    .gap_ok(gap_ok)
  );

  // Entry storage: ranges only, no payload
  always_ff @(posedge clk) begin
    if (do_merge) begin
      ent_addr[merge_idx] <= merge_lo;
      ent_len[merge_idx]  <= merge_len;
    end else if (alloc) begin
      ent_addr[tail] <= wr_addr;
      ent_len[tail]  <= wr_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      count_q <= '0;
    end else begin
      if (drain_fire) head_q <= head_q + 1'b1;
      count_q <= count_q + CW'(alloc) - CW'(drain_fire);
    end
  end

  assign occupancy  = count_q;
  assign drain_addr = ent_addr[head_q];
  assign drain_len  = ent_len[head_q];

endmodule

// File: rtl/wbuf_merge_drain_chk.sv
`timescale 1ns/1ps
module wbuf_merge_drain_chk #(
  parameter int DEPTH  = 8,
  parameter int CW     = 4,
  parameter int LEN_W  = 7,
  parameter int BURST  = 64,
  parameter int HI_CNT = 8,
  parameter int LO_CNT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             rdq_empty,
  input logic             mode_write,
  input logic [CW-1:0]    occupancy,
  input logic             drain_valid,
  input logic             drain_fire,
  input logic [LEN_W-1:0] drain_len,
  input logic             merge_hit
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CW'(DEPTH)) else $error("occupancy above depth"); // R7

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == CW'(DEPTH) && !drain_fire) |=> (occupancy == CW'(DEPTH))) else $error("full buffer changed without drain"); // R7

  AST_MERGE_KEEPS_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && merge_hit && !drain_fire) |=> $stable(occupancy)) else $error("merge changed occupancy"); // R3

  AST_HI_ENTERS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_write && occupancy >= CW'(HI_CNT)) |=> mode_write) else $error("high mark missed"); // R8

  AST_IDLE_ENTERS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_write && rdq_empty && occupancy != '0) |=> mode_write) else $error("idle reads did not start drain"); // R9

  AST_EMPTY_LEAVES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_write && occupancy == '0) |=> !mode_write) else $error("empty buffer kept write mode"); // R10

  AST_LOW_LEAVES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_write && occupancy < CW'(LO_CNT) && !rdq_empty) |=> !mode_write) else $error("low mark missed"); // R10

  AST_DRAIN_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    drain_valid |-> (mode_write && occupancy != '0)) else $error("drain outside write mode"); // R11

  AST_ISSUE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    drain_fire |=> !drain_fire) else $error("back to back removal"); // R12

  AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    drain_valid |-> (drain_len != '0 && drain_len <= LEN_W'(BURST))) else $error("drained length out of range"); // R5

endmodule

bind wbuf_merge_drain wbuf_merge_drain_chk #(
  .DEPTH(DEPTH), .CW(CW), .LEN_W(LEN_W), .BURST(BURST), .HI_CNT(HI_CNT), .LO_CNT(LO_CNT)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .rdq_empty  (rdq_empty),
  .mode_write (mode_write),
  .occupancy  (occupancy),
  .drain_valid(drain_valid),
  .drain_fire (drain_fire),
  .drain_len  (drain_len),
  .merge_hit  (merge_hit)
);

// File: tb/wbuf_merge_drain_tb.sv
`timescale 1ns/1ps
module wbuf_merge_drain_tb_top;

  localparam int D   = 8;
  localparam int HI  = 8;
  localparam int LO  = 4;
  localparam int GP  = 4;
  localparam int BL  = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_addr = '0;
  logic [6:0]  wr_len = '0;
  logic        wr_ready;
  logic        rdq_empty = 1'b0;
  logic        mode_write;
  logic [3:0]  occupancy;
  logic        drain_valid;
  logic [31:0] drain_addr;
  logic [6:0]  drain_len;
  logic        drain_ready = 1'b0;

  always #2 clk = ~clk;

  wbuf_merge_drain dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_len(wr_len),
    .wr_ready(wr_ready), .rdq_empty(rdq_empty), .mode_write(mode_write), .occupancy(occupancy),
    .drain_valid(drain_valid), .drain_addr(drain_addr), .drain_len(drain_len),
    .drain_ready(drain_ready)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Reference model of the buffer
  longint m_addr [D];
  int     m_len  [D];
  int     m_head = 0, m_cnt = 0, m_gap = 0;
  bit     m_mode = 0;

  task automatic chk(string tag, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Two ranges meet unless one finishes strictly before the other begins
  function automatic bit b_meet(longint s, int n, longint a, int l);
    return !((a > s + n) || (s > a + l));
  endfunction

  function automatic longint b_lo(longint s, longint a);
    return (a < s) ? a : s;
  endfunction

  function automatic int b_span(longint s, int n, longint a, int l);
    longint top;
    top = (s + n > a + l) ? s + n : a + l;
    return int'(top - b_lo(s, a));
  endfunction

  task automatic step(bit v, longint a, int l, bit rqe, bit dr);
    bit ev, ef, hit, ready, nm;
    int hidx;
    @(negedge clk);
    ev = m_mode && (m_cnt > 0) && (m_gap == 0);
    chk("R2 R3 R4 R5 R7 occupancy", occupancy, m_cnt);
    chk("R8 R9 R10 mode_write", mode_write, m_mode);
    chk("R11 R12 drain_valid", drain_valid, ev);
    if (ev) begin
      chk("R6 R11 drain_addr", drain_addr, m_addr[m_head]);
      chk("R5 R11 drain_len", drain_len, m_len[m_head]);
    end
    wr_valid = v; wr_addr = 32'(a); wr_len = 7'(l); rdq_empty = rqe; drain_ready = dr;
    #1;
    ef = ev && dr;
    hit = 0; hidx = 0;
    for (int k = 0; k < m_cnt; k++) begin
      int i;
      i = (m_head + k) % D;
      if (!hit && !(k == 0 && ef) && b_meet(m_addr[i], m_len[i], a, l) &&
          b_span(m_addr[i], m_len[i], a, l) <= BL) begin
        hit = 1; hidx = i;
      end
    end
    ready = hit || (m_cnt < D);
    chk("R7 wr_ready", wr_ready, ready);
    if (m_mode) nm = !((m_cnt == 0) || (m_cnt < LO && !rqe));
    else        nm = (m_cnt >= HI) || (rqe && m_cnt > 0);
    if (v && ready) begin
      if (hit) begin
        m_len[hidx]  = b_span(m_addr[hidx], m_len[hidx], a, l);
        m_addr[hidx] = b_lo(m_addr[hidx], a);
      end else begin
        m_addr[(m_head + m_cnt) % D] = a;
        m_len[(m_head + m_cnt) % D]  = l;
        m_cnt++;
      end
    end
    if (ef) begin m_head = (m_head + 1) % D; m_cnt--; end
    m_gap  = ef ? GP - 1 : ((m_gap > 0) ? m_gap - 1 : 0);
    m_mode = nm;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 occupancy", occupancy, 0);
    chk("R1 mode_write", mode_write, 0);
    chk("R1 drain_valid", drain_valid, 0);
    chk("R1 wr_ready", wr_ready, 1);

    // Merging: overlap, follow, precede
    step(1, 'h100, 16, 0, 0);            // R2 new slot
    step(1, 'h108, 16, 0, 0);            // R3 overlap -> 0x100..0x118
    step(1, 'h118, 8, 0, 0);             // R4 follows -> 0x100..0x120
    step(1, 'h0F0, 16, 0, 0);            // R4 precedes -> 0xF0..0x120
    step(0, 0, 1, 0, 0);
    chk("R3 R4 merged into one entry", occupancy, 1);
    step(1, 'h120, 32, 0, 0);            // R5 union would be 80 bytes
    step(0, 0, 1, 0, 0);
    chk("R5 oversize union takes new slot", occupancy, 2);
    for (int i = 1; i <= 6; i++) step(1, 'h1000 * i, 8, 0, 0);
    step(0, 0, 1, 0, 0);
    chk("R7 buffer full", occupancy, 8);
    chk("R8 not yet in write mode", mode_write, 0);
    step(1, 'h9000, 4, 0, 0);
    chk("R7 full buffer refuses", wr_ready, 0);
    chk("R8 full buffer starts drain", mode_write, 1);
    step(0, 0, 1, 0, 0);
    chk("R7 refused write ignored", occupancy, 8);
    chk("R11 oldest entry offered addr", drain_addr, 'hF0);
    chk("R4 R11 oldest entry offered len", drain_len, 48);
    for (int i = 0; i < 30; i++) step(0, 0, 1, 0, 1);
    chk("R10 low mark returns to reads", mode_write, 0);
    chk("R10 R12 occupancy at low mark", occupancy, 3);
    for (int i = 0; i < 40; i++) step(0, 0, 1, 1, 1);
    chk("R9 R10 idle reads drain to empty", occupancy, 0);
    chk("R10 empty returns to reads", mode_write, 0);

    // Random traffic in a narrow window so ranges meet often
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 3) != 0, longint'($urandom % 1024), 1 + int'($urandom % 64),
           ($urandom % 4) == 0, ($urandom % 2) == 1);
    end
    step(0, 0, 1, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule